// File: doc/BRIEF.md
# LUT Cascade Eye-Window Classifier

The block scores every 15×15 window of an image whose pixels have already been replaced by 9-bit local census codes. The codes arrive in raster order, one per accepted clock, with a start-of-frame marker on the first pixel. Three classifier stages look at the current window at the same time. Each stage picks a fixed set of window positions, looks up a signed weight for the census code found at each position, and adds the weights together. A window is a candidate when every stage total lies below that stage's threshold. For each completed window the block reports the window's top-left coordinate, whether it passed, and its final-stage total. It also keeps the strongest candidate of the frame and reports it when the last pixel has been processed.

The three stages share one window store, made of fourteen line buffers and a 15×15 register array. Each stage is a registered adder tree padded to a common depth, so all three totals for a window appear in the same cycle. The weight tables are generated at elaboration time by a closed-form rule, so the block needs no table memory and no loading step.

Top module: `eye_cascade_top`

## Requirements
- R1: After a synchronous active-low reset, `win_valid`, `win_pass`, `frame_done` and `frame_found` are low until pixels are accepted.
- R2: The image is IMG_W×IMG_H (defaults 24×20) in raster order. A pixel with `code_sof` high is pixel (0,0). The pixel at column x, row y completes a window when x ≥ 14 and y ≥ 14, and that window is reported once with `win_x` = x−14 and `win_y` = y−14.
- R3: Feature k (counted from 0) of stage s (s = 0, 1, 2, with 22, 36 and 100 features) reads window row (7k+3s) mod 15 and column (4k+5s+⌊k/15⌋) mod 15. Row 0 and column 0 are the window's top-left. With key = (37k+101s+5) mod 512, its weight is popcount(code XOR key) − 4.
- R4: A stage total is the sum of its feature weights. `win_pass` is high only when the totals of stages 0, 1 and 2 are below 12, 18 and 50 respectively. `win_conf` is the stage-2 total as a signed two's-complement value.
- R5: The result of a window appears on the outputs right after the 9th rising edge that follows the edge which accepted its completing pixel. One window result is produced per accepted pixel.
- R6: `frame_done` pulses for one cycle, in the same cycle as the result of the last pixel (IMG_W−1, IMG_H−1). `frame_found` then says whether any window of the frame passed. `best_x`, `best_y` and `best_conf` give the passing window with the largest `win_conf`. When several windows tie, the earliest one in raster order is kept.
- R7: A frame in which no window passes reports `frame_found` low.
- R8: A `code_sof` pixel discards the candidate of a frame that was abandoned before its last pixel.
- R9: Cycles with `code_valid` low do not advance the position counters and do not change any window result or the frame outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_valid | input | 1 | A census code is presented this cycle |
| code_sof | input | 1 | The presented code is pixel (0,0) of a new frame |
| code_in | input | 9 | Census code |
| win_valid | output | 1 | A window result is present |
| win_pass | output | 1 | The window passed all three stages |
| win_x | output | 5 | Window top-left column |
| win_y | output | 5 | Window top-left row |
| win_conf | output | 11 | Final-stage total, signed |
| frame_done | output | 1 | One-cycle pulse: frame outcome valid |
| frame_found | output | 1 | At least one window passed in the frame |
| best_x | output | 5 | Column of the best candidate |
| best_y | output | 5 | Row of the best candidate |
| best_conf | output | 11 | Final-stage total of the best candidate, signed |

## Verification
The bench uses several kinds of input. Pseudo-random code frames spread the stage totals across the thresholds, so every window's pass bit and total are compared against an independent computation, and the frame maximum must be picked from among many distinct candidates. A frame sent with idle gaps between pixels must give the same results as one sent without gaps, at the same latency counted from each accepting edge. Flat frames built from a code that passes every stage make every window tie, which shows whether the earliest window is kept. A flat frame built from a failing code checks the not-found outcome. A frame abandoned part-way through and followed by a new start of frame shows whether a stale candidate leaks into the next result.

// File: rtl/eye_cascade_pkg.sv
// Shared constants, types and the elaboration-time feature rules used by
// every stage of the window classifier. Assumes 9-bit census codes and a
// square window.
package eye_cascade_pkg;

    localparam int CODE_W = 9;
    localparam int WIN    = 15;
    localparam int NSTAGE = 3;

    typedef logic [CODE_W-1:0] code_t;

    // Window row tapped by feature idx of a stage.
    function automatic int tap_row(input int stage, input int idx);
        return (idx * 7 + stage * 3) % WIN;
    endfunction

    // Window column tapped by feature idx of a stage.
    function automatic int tap_col(input int stage, input int idx);
        return (idx * 4 + stage * 5 + idx / WIN) % WIN;
    endfunction

    // Code key against which the feature measures distance.
    function automatic int tap_key(input int stage, input int idx);
        return (idx * 37 + stage * 101 + 5) % (1 << CODE_W);
    endfunction

    // Signed weight of one feature for a given code (table as a rule).
    function automatic logic signed [4:0] tap_weight(input code_t code,
                                                     input int stage,
                                                     input int idx);
        int ones;
        ones = $countones(code ^ code_t'(tap_key(stage, idx)));
        return 5'(ones - 4);
    endfunction

endpackage

// File: rtl/eye_window_store.sv
// Window store: fourteen line buffers feed a 15x15 register array whose
// right-most column is the newest pixel. Assumes the caller supplies the
// column index of each accepted pixel; rows above row 14 of a frame hold
// stale data and must be masked by the caller.
module eye_window_store
    import eye_cascade_pkg::*;
#(
    parameter int IMG_W = 24,
    parameter int XW    = $clog2(IMG_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          px_valid,
    input  logic [XW-1:0] px_x,
    input  code_t         px_code,
    output code_t         win [WIN][WIN]
);

    localparam int NBUF = WIN - 1;

    code_t line_mem [NBUF][IMG_W];
    code_t column   [WIN];

    // Assemble the incoming column: buffered rows above, live pixel at the bottom.
    always_comb begin
        for (int r = 0; r < NBUF; r++) begin
            column[r] = line_mem[r][px_x];
        end
        column[WIN-1] = px_code;
    end

    // Each buffer takes the pixel one row below it at the same column.
    always_ff @(posedge clk) begin
        if (px_valid) begin
            for (int r = 0; r < NBUF; r++) begin
                line_mem[r][px_x] <= column[r+1];
            end
        end
    end

    // Shift the window left by one column and load the new column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < WIN; r++) begin
                for (int c = 0; c < WIN; c++) begin
                    win[r][c] <= '0;
                end
            end
        end else if (px_valid) begin
            for (int r = 0; r < WIN; r++) begin
                for (int c = 0; c < WIN - 1; c++) begin
                    win[r][c] <= win[r][c+1];
                end
                win[r][WIN-1] <= column[r];
            end
        end
    end

endmodule

// File: rtl/eye_stage_sum.sv
// One classifier stage: registered weight lookups at the stage's tap
// positions, then a registered binary adder tree of LEVELS levels. The
// tree is zero-padded, so every stage built with the same LEVELS has the
// same latency of LEVELS+1 cycles from the window to sum_o.
module eye_stage_sum
    import eye_cascade_pkg::*;
#(
    parameter int STAGE  = 0,
    parameter int NFEAT  = 22,
    parameter int LEVELS = 7,
    parameter int SUM_W  = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  code_t                   win [WIN][WIN],
    output logic signed [SUM_W-1:0] sum_o
);

    localparam int LEAVES = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        logic signed [SUM_W-1:0] node [1 << (LEVELS - l)];

        if (l == 0) begin : g_leaf
            // Look up each feature weight; unused leaves hold zero.
            always_ff @(posedge clk) begin
                for (int j = 0; j < LEAVES; j++) begin
                    if (!rst_n || j >= NFEAT) begin
                        node[j] <= '0;
                    end else begin
                        node[j] <= SUM_W'(tap_weight(
                            win[tap_row(STAGE, j)][tap_col(STAGE, j)], STAGE, j));
                    end
                end
            end
        end else begin : g_add
            // Add neighbouring pairs of the level below.
            always_ff @(posedge clk) begin
                for (int j = 0; j < (1 << (LEVELS - l)); j++) begin
                    if (!rst_n) begin
                        node[j] <= '0;
                    end else begin
                        node[j] <= g_lvl[l-1].node[2*j] + g_lvl[l-1].node[2*j+1];
                    end
                end
            end
        end
    end

    assign sum_o = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/eye_best_track.sv
// Output stage: registers the per-window result and keeps the strongest
// passing window of the frame (strictly larger replaces, so ties keep the
// earliest). Assumes in_sof and in_last are aligned with the window result
// of the same pixel.
module eye_best_track #(
    parameter int XW    = 5,
    parameter int YW    = 5,
    parameter int SUM_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_win,
    input  logic                    in_pass,
    input  logic [XW-1:0]           in_x,
    input  logic [YW-1:0]           in_y,
    input  logic signed [SUM_W-1:0] in_conf,
    input  logic                    in_sof,
    input  logic                    in_last,
    output logic                    win_valid,
    output logic                    win_pass,
    output logic [XW-1:0]           win_x,
    output logic [YW-1:0]           win_y,
    output logic [SUM_W-1:0]        win_conf,
    output logic                    frame_done,
    output logic                    frame_found,
    output logic [XW-1:0]           best_x,
    output logic [YW-1:0]           best_y,
    output logic [SUM_W-1:0]        best_conf
);

    logic                    have_q;
    logic [XW-1:0]           bx_q;
    logic [YW-1:0]           by_q;
    logic signed [SUM_W-1:0] bc_q;

    logic                    base_have;
    logic                    take;
    logic                    nxt_have;
    logic [XW-1:0]           nxt_x;
    logic [YW-1:0]           nxt_y;
    logic signed [SUM_W-1:0] nxt_c;

    // Decide whether the current window replaces the held candidate.
    always_comb begin
        base_have = in_sof ? 1'b0 : have_q;
        take      = in_win && in_pass && (!base_have || (in_conf > bc_q));
        nxt_have  = base_have || take;
        nxt_x     = take ? in_x : bx_q;
        nxt_y     = take ? in_y : by_q;
        nxt_c     = take ? in_conf : bc_q;
    end

    // Hold the running candidate; a finished frame empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            bx_q   <= '0;
            by_q   <= '0;
            bc_q   <= '0;
        end else begin
            have_q <= in_last ? 1'b0 : nxt_have;
            bx_q   <= nxt_x;
            by_q   <= nxt_y;
            bc_q   <= nxt_c;
        end
    end

    // Register the per-window result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_pass  <= 1'b0;
            win_x     <= '0;
            win_y     <= '0;
            win_conf  <= '0;
        end else begin
            win_valid <= in_win;
            win_pass  <= in_win && in_pass;
            win_x     <= in_x;
            win_y     <= in_y;
            win_conf  <= in_conf;
        end
    end

    // Publish the frame outcome on the last pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done  <= 1'b0;
            frame_found <= 1'b0;
            best_x      <= '0;
            best_y      <= '0;
            best_conf   <= '0;
        end else begin
            frame_done <= in_last;
            if (in_last) begin
                frame_found <= nxt_have;
                best_x      <= nxt_have ? nxt_x : '0;
                best_y      <= nxt_have ? nxt_y : '0;
                best_conf   <= nxt_have ? nxt_c : '0;
            end
        end
    end

endmodule

// File: rtl/eye_cascade_top.sv
// Three-stage cascade classifier over a raster stream of census codes.
// Tracks the pixel position, feeds the shared window store, runs all
// stages side by side with equal latency and carries position data along
// a matching delay line. Assumes code_sof accompanies pixel (0,0).
module eye_cascade_top
    import eye_cascade_pkg::*;
#(
    parameter int IMG_W = 24,
    parameter int IMG_H = 20,
    parameter int NF1   = 22,
    parameter int NF2   = 36,
    parameter int NF3   = 100,
    parameter int THR1  = 12,
    parameter int THR2  = 18,
    parameter int THR3  = 50,
    localparam int XW     = $clog2(IMG_W),
    localparam int YW     = $clog2(IMG_H),
    localparam int NMAX   = (NF1 > NF2) ? ((NF1 > NF3) ? NF1 : NF3)
                                        : ((NF2 > NF3) ? NF2 : NF3),
    localparam int SUM_W  = $clog2(NMAX * 5 + 1) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic              code_sof,
    input  logic [CODE_W-1:0] code_in,
    output logic              win_valid,
    output logic              win_pass,
    output logic [XW-1:0]     win_x,
    output logic [YW-1:0]     win_y,
    output logic [SUM_W-1:0]  win_conf,
    output logic              frame_done,
    output logic              frame_found,
    output logic [XW-1:0]     best_x,
    output logic [YW-1:0]     best_y,
    output logic [SUM_W-1:0]  best_conf
);

    localparam int LEVELS = $clog2(NMAX);
    localparam int PIPE   = LEVELS + 2;
    localparam int NF_TAB  [NSTAGE] = '{NF1, NF2, NF3};
    localparam int THR_TAB [NSTAGE] = '{THR1, THR2, THR3};

    typedef struct packed {
        logic          vld;
        logic          sof;
        logic          last;
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } meta_t;

    logic [XW-1:0] nx_q;
    logic [YW-1:0] ny_q;
    logic [XW-1:0] px;
    logic [YW-1:0] py;
    logic          px_last;

    meta_t meta [PIPE];
    meta_t tail;

    code_t                   win [WIN][WIN];
    logic signed [SUM_W-1:0] ssum [NSTAGE];
    logic [NSTAGE-1:0]       stage_ok;

    logic          out_win;
    logic [XW-1:0] out_x;
    logic [YW-1:0] out_y;

    // Position of the pixel presented this cycle.
    always_comb begin
        px      = code_sof ? '0 : nx_q;
        py      = code_sof ? '0 : ny_q;
        px_last = (px == XW'(IMG_W - 1)) && (py == YW'(IMG_H - 1));
    end

    // Advance the raster position on each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nx_q <= '0;
            ny_q <= '0;
        end else if (code_valid) begin
            if (px == XW'(IMG_W - 1)) begin
                nx_q <= '0;
                ny_q <= (py == YW'(IMG_H - 1)) ? '0 : py + 1'b1;
            end else begin
                nx_q <= px + 1'b1;
                ny_q <= py;
            end
        end
    end

    // Delay line carrying position data alongside the adder trees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE; i++) begin
                meta[i] <= '0;
            end
        end else begin
            meta[0] <= '{vld: code_valid, sof: code_valid && code_sof,
                         last: code_valid && px_last, x: px, y: py};
            for (int i = 1; i < PIPE; i++) begin
                meta[i] <= meta[i-1];
            end
        end
    end

    eye_window_store #(
        .IMG_W (IMG_W),
        .XW    (XW)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .px_valid (code_valid),
        .px_x     (px),
        .px_code  (code_in),
        .win      (win)
    );

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        eye_stage_sum #(
            .STAGE  (s),
            .NFEAT  (NF_TAB[s]),
            .LEVELS (LEVELS),
            .SUM_W  (SUM_W)
        ) sum_i (
            .clk   (clk),
            .rst_n (rst_n),
            .win   (win),
            .sum_o (ssum[s])
        );
        assign stage_ok[s] = ssum[s] < SUM_W'(THR_TAB[s]);
    end

    // Qualify the delayed position as a complete window.
    always_comb begin
        tail    = meta[PIPE-1];
        out_win = tail.vld && (tail.x >= XW'(WIN - 1)) && (tail.y >= YW'(WIN - 1));
        out_x   = tail.x - XW'(WIN - 1);
        out_y   = tail.y - YW'(WIN - 1);
    end

    eye_best_track #(
        .XW    (XW),
        .YW    (YW),
        .SUM_W (SUM_W)
    ) track_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_win      (out_win),
        .in_pass     (&stage_ok),
        .in_x        (out_x),
        .in_y        (out_y),
        .in_conf     (ssum[NSTAGE-1]),
        .in_sof      (tail.sof),
        .in_last     (tail.last),
        .win_valid   (win_valid),
        .win_pass    (win_pass),
        .win_x       (win_x),
        .win_y       (win_y),
        .win_conf    (win_conf),
        .frame_done  (frame_done),
        .frame_found (frame_found),
        .best_x      (best_x),
        .best_y      (best_y),
        .best_conf   (best_conf)
    );

endmodule

// File: rtl/eye_cascade_chk.sv
// Property checker for the cascade classifier, attached by bind. Keeps its
// own running maximum of passing windows between frame outcomes.
module eye_cascade_chk #(
    parameter int IMG_W = 24,
    parameter int IMG_H = 20,
    parameter int THR3  = 50,
    parameter int XW    = 5,
    parameter int YW    = 5,
    parameter int SUM_W = 11,
    parameter int LAT   = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             code_valid,
    input logic             win_valid,
    input logic             win_pass,
    input logic [XW-1:0]    win_x,
    input logic [YW-1:0]    win_y,
    input logic [SUM_W-1:0] win_conf,
    input logic             frame_done,
    input logic             frame_found,
    input logic [SUM_W-1:0] best_conf
);

    logic                    run_any;
    logic signed [SUM_W-1:0] run_max;
    logic                    cur_any;
    logic signed [SUM_W-1:0] cur_max;

    // Fold the current passing window into the running maximum.
    always_comb begin
        cur_any = run_any || win_pass;
        cur_max = run_max;
        if (win_pass && (!run_any || ($signed(win_conf) > run_max))) begin
            cur_max = $signed(win_conf);
        end
    end

    // Running maximum since the last frame outcome.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_done) begin
            run_any <= 1'b0;
            run_max <= '0;
        end else begin
            run_any <= cur_any;
            run_max <= cur_max;
        end
    end

    assert_pass_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_pass |-> win_valid);

    assert_pass_below_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_pass |-> ($signed(win_conf) < THR3));

    assert_coord_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (int'(win_x) <= IMG_W - 15) && (int'(win_y) <= IMG_H - 15));

    assert_result_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> $past(code_valid, LAT + 1));

    assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(code_valid, LAT + 1));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_best_is_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_found) |-> (cur_any && ($signed(best_conf) >= cur_max)));

endmodule

bind eye_cascade_top eye_cascade_chk #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .THR3  (THR3),
    .XW    (XW),
    .YW    (YW),
    .SUM_W (SUM_W),
    .LAT   ($clog2(NMAX) + 2)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .code_valid  (code_valid),
    .win_valid   (win_valid),
    .win_pass    (win_pass),
    .win_x       (win_x),
    .win_y       (win_y),
    .win_conf    (win_conf),
    .frame_done  (frame_done),
    .frame_found (frame_found),
    .best_conf   (best_conf)
);

// File: tb/eye_cascade_top_tb_top.sv
`timescale 1ns/1ps
module eye_cascade_top_tb_top;

    localparam int W     = 24;
    localparam int H     = 20;
    localparam int XW    = 5;
    localparam int YW    = 5;
    localparam int SUM_W = 11;
    localparam int LAT   = 9;
    localparam int NWX   = W - 14;
    localparam int NWY   = H - 14;

    int nf  [3] = '{22, 36, 100};
    int thr [3] = '{12, 18, 50};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             code_valid = 1'b0;
    logic             code_sof = 1'b0;
    logic [8:0]       code_in = '0;
    logic             win_valid, win_pass, frame_done, frame_found;
    logic [XW-1:0]    win_x, best_x;
    logic [YW-1:0]    win_y, best_y;
    logic [SUM_W-1:0] win_conf, best_conf;

    always #4 clk = ~clk;

    eye_cascade_top dut_i (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_sof(code_sof),
        .code_in(code_in), .win_valid(win_valid), .win_pass(win_pass),
        .win_x(win_x), .win_y(win_y), .win_conf(win_conf),
        .frame_done(frame_done), .frame_found(frame_found),
        .best_x(best_x), .best_y(best_y), .best_conf(best_conf)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int edge_cnt = 0;

    int img      [H][W];
    int acc_edge [H][W];
    int exp_conf [NWY][NWX];
    bit exp_pass [NWY][NWX];
    bit seen     [NWY][NWX];
    int exp_found, exp_bx, exp_by, exp_bc;
    int got_done, got_found, got_bx, got_by, got_bc;
    int n_seen;
    int unsigned seed = 32'h1234_5678;

    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 feature rule, written from the requirement.
    function automatic int weight(input int code, input int s, input int k);
        int key = (k * 37 + s * 101 + 5) % 512;
        return $countones(code ^ key) - 4;
    endfunction

    function automatic int stage_total(input int s, input int wx, input int wy);
        int t = 0;
        for (int k = 0; k < nf[s]; k++) begin
            int r = (k * 7 + s * 3) % 15;
            int c = (k * 4 + s * 5 + k / 15) % 15;
            t += weight(img[wy + r][wx + c], s, k);
        end
        return t;
    endfunction

    function automatic int flat_total(input int s, input int code);
        int t = 0;
        for (int k = 0; k < nf[s]; k++) t += weight(code, s, k);
        return t;
    endfunction

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 16) & 511);
    endfunction

    // Expected window results and frame outcome (R4, R6).
    task automatic compute_expect();
        exp_found = 0; exp_bx = 0; exp_by = 0; exp_bc = 0; n_seen = 0;
        for (int wy = 0; wy < NWY; wy++) begin
            for (int wx = 0; wx < NWX; wx++) begin
                int t0 = stage_total(0, wx, wy);
                int t1 = stage_total(1, wx, wy);
                int t2 = stage_total(2, wx, wy);
                exp_conf[wy][wx] = t2;
                exp_pass[wy][wx] = (t0 < thr[0]) && (t1 < thr[1]) && (t2 < thr[2]);
                seen[wy][wx] = 1'b0;
                if (exp_pass[wy][wx] && (exp_found == 0 || t2 > exp_bc)) begin
                    exp_found = 1; exp_bx = wx; exp_by = wy; exp_bc = t2;
                end
            end
        end
    endtask

    // Per-window monitor: R2 coordinates, R3/R4 values, R5 latency.
    always @(negedge clk) begin
        if (rst_n && win_valid) begin
            int wx, wy;
            wx = int'(win_x); wy = int'(win_y);
            if (wx < NWX && wy < NWY) begin
                check(win_pass == exp_pass[wy][wx], "R4", "window pass bit",
                      int'(win_pass), int'(exp_pass[wy][wx]));
                check(int'($signed(win_conf)) == exp_conf[wy][wx], "R3", "window confidence",
                      int'($signed(win_conf)), exp_conf[wy][wx]);
                check(edge_cnt - acc_edge[wy + 14][wx + 14] == LAT, "R5", "result latency",
                      edge_cnt - acc_edge[wy + 14][wx + 14], LAT);
                check(!seen[wy][wx], "R2", "window reported once", 1, 0);
                seen[wy][wx] = 1'b1;
                n_seen++;
            end else begin
                check(1'b0, "R2", "window coordinate in range", wx * 100 + wy, 0);
            end
        end
        if (rst_n && frame_done) begin
            got_done  = 1;
            got_found = int'(frame_found);
            got_bx    = int'(best_x);
            got_by    = int'(best_y);
            got_bc    = int'($signed(best_conf));
        end
    end

    task automatic drive_rows(input int rows, input bit gaps);
        for (int y = 0; y < rows; y++) begin
            for (int x = 0; x < W; x++) begin
                @(negedge clk);
                if (gaps && ((x + 2 * y) % 3 == 0)) begin
                    code_valid = 1'b0;
                    code_sof   = 1'b0;
                    @(negedge clk);
                end
                code_valid = 1'b1;
                code_sof   = (x == 0 && y == 0);
                code_in    = 9'(img[y][x]);
                acc_edge[y][x] = edge_cnt + 1;
            end
        end
        @(negedge clk);
        code_valid = 1'b0;
        code_sof   = 1'b0;
    endtask

    task automatic run_frame(input string tag, input bit gaps, input string req);
        compute_expect();
        got_done = 0;
        drive_rows(H, gaps);
        for (int i = 0; i < 40 && got_done == 0; i++) @(negedge clk);
        check(got_done == 1, "R6", {tag, " frame outcome reported"}, got_done, 1);
        check(n_seen == NWX * NWY, "R2", {tag, " window count"}, n_seen, NWX * NWY);
        check(got_found == exp_found, req, {tag, " found flag"}, got_found, exp_found);
        if (exp_found != 0) begin
            check(got_bx == exp_bx, req, {tag, " best column"}, got_bx, exp_bx);
            check(got_by == exp_by, req, {tag, " best row"}, got_by, exp_by);
            check(got_bc == exp_bc, req, {tag, " best confidence"}, got_bc, exp_bc);
        end
    endtask

    task automatic fill_random();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = next_rand();
    endtask

    task automatic fill_flat(input int code);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) img[y][x] = code;
    endtask

    // R1: quiet outputs after reset.
    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(win_valid == 1'b0, "R1", "win_valid after reset", int'(win_valid), 0);
        check(win_pass == 1'b0, "R1", "win_pass after reset", int'(win_pass), 0);
        check(frame_done == 1'b0, "R1", "frame_done after reset", int'(frame_done), 0);
        check(frame_found == 1'b0, "R1", "frame_found after reset", int'(frame_found), 0);
    endtask

    // R4/R6: random codes, maximum picked among distinct totals.
    task automatic test_random();
        fill_random();
        run_frame("random A", 1'b0, "R6");
        fill_random();
        run_frame("random B", 1'b0, "R6");
    endtask

    // R9: idle gaps leave results unchanged.
    task automatic test_gaps();
        fill_random();
        run_frame("gapped", 1'b1, "R9");
    endtask

    // R6 ties and R7 none-found, with R8 abandoned-frame clearing.
    task automatic test_flat();
        int pass_code = -1;
        int fail_code = -1;
        for (int c = 0; c < 512; c++) begin
            if (pass_code < 0 && flat_total(0, c) < thr[0] && flat_total(1, c) < thr[1]
                && flat_total(2, c) < thr[2]) pass_code = c;
            if (fail_code < 0 && flat_total(0, c) >= thr[0]) fail_code = c;
        end
        check(pass_code >= 0, "R6", "flat passing code exists", pass_code, 0);
        if (pass_code >= 0) begin
            fill_flat(pass_code);
            run_frame("flat tie R6", 1'b0, "R6");
            check(got_bx == 0 && got_by == 0, "R6", "tie keeps earliest window",
                  got_bx * 100 + got_by, 0);
        end
        fill_flat(fail_code);
        run_frame("flat none R7", 1'b0, "R7");
        if (pass_code >= 0) begin
            fill_flat(pass_code);
            compute_expect();
            got_done = 0;
            drive_rows(17, 1'b0);
            repeat (14) @(negedge clk);
            check(got_done == 0, "R6", "no outcome for abandoned frame", got_done, 0);
        end
        fill_flat(fail_code);
        run_frame("after abandon R8", 1'b0, "R8");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_random();
        test_gaps();
        test_flat();
        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule